// File: doc/BRIEF.md
# Block Output Completion Tracker

This block follows one atomic instruction block through execution in a block-structured dataflow core. When the block is dispatched, a header announces two expectation masks: one for the register writes the block will produce, organised as banks of write slots, and one for the store identifiers it will emit. During execution the tracker receives register-write, store and branch completion events. Each event retires its bit. Register writes are only recorded as completions here, because architectural registers change only at the block boundary.

The block may commit once three separate output classes are all complete: every expected register write has arrived, every expected store has arrived, and exactly one branch has been seen. At that point the tracker raises a single-cycle commit-ready pulse and goes back to idle to wait for the next header. Any event that breaks the protocol sets a sticky error flag. Examples are an event for a bit that was never expected, a duplicate event, a second branch, a header that arrives while a block is still being tracked, or an event that arrives while the tracker is idle. While the error flag is set, commit is suppressed. A synchronous flush clears all tracking state, including the error flag, in one cycle.

Top module: `blk_commit_tracker`

## Requirements
- R1: A header (hdr_valid high) accepted while the tracker is idle loads both expectation masks, and busy reads 1 from the next cycle.
- R2: A register-write event with bank b and slot s retires expected-write bit b*8+s. Commit requires that every expected-write bit has been retired.
- R3: A store event with identifier n retires expected-store bit n. Commit requires that every expected-store bit has been retired.
- R4: Exactly one branch is required per block. While no branch has been seen, commit_ready stays 0. A second branch in the same block sets err.
- R5: commit_ready is 1 for exactly one cycle, in the cycle after the last outstanding output event is registered. In the cycle after that, busy is 0.
- R6: An event whose bit is not pending, whether never expected or already retired, sets err. err stays set and commit_ready stays 0 until a flush or reset.
- R7: A flush returns the tracker in one cycle to busy=0, err=0, commit_ready=0, with no pending expectations.
- R8: A header that arrives while busy is dropped and sets err.
- R9: Any write, store or branch event that arrives while the tracker is idle sets err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of all tracking state |
| hdr_valid | input | 1 | Header strobe for a dispatched block |
| hdr_wr_mask | input | 32 | Expected register writes, bit = bank*8+slot |
| hdr_st_mask | input | 32 | Expected store identifiers |
| wr_valid | input | 1 | Register-write completion event |
| wr_bank | input | 2 | Bank of the write event |
| wr_slot | input | 3 | Slot within the bank |
| st_valid | input | 1 | Store completion event |
| st_id | input | 5 | Store identifier |
| br_valid | input | 1 | Branch completion event |
| busy | output | 1 | A block is being tracked |
| commit_ready | output | 1 | One-cycle pulse: the block may commit |
| err | output | 1 | Sticky protocol error |

## Verification
Every one of the 32 bank/slot write positions is swept, and so is every one of the 32 store identifiers, each alone with a single expected bit. This shows that the bank-times-slot index lands on the right bit, and that commit waits for the branch. A full block with all 64 expectations, retired in reverse order with the branch first, shows that commit fires only on the very last output and not earlier. Events on the wrong bank, duplicate events, a second branch, an early header and events while idle are then each applied alone, to show that every one of them sets the sticky error and holds commit off until a flush. After each flush a clean block follows, to show that the flush restores normal operation.

// File: rtl/blkdone_pkg.sv
package blkdone_pkg;
    localparam int NUM_BANKS      = 4;
    localparam int SLOTS_PER_BANK = 8;
    localparam int NUM_STORE_IDS  = 32;

    localparam int REG_OUTS = NUM_BANKS * SLOTS_PER_BANK;
    localparam int BANK_W   = $clog2(NUM_BANKS);
    localparam int SLOT_W   = $clog2(SLOTS_PER_BANK);
    localparam int REG_IW   = BANK_W + SLOT_W;
    localparam int STID_W   = $clog2(NUM_STORE_IDS);

    typedef enum logic {
        TRK_IDLE = 1'b0,
        TRK_BUSY = 1'b1
    } trk_state_e;

    // Bank-major position of a register output: bank*SLOTS_PER_BANK + slot
    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [SLOT_W-1:0] slot;
    } reg_tag_t;

    typedef struct packed {
        logic wr_bad;
        logic st_bad;
        logic br_bad;
        logic hdr_bad;
    } proto_viol_t;

    function automatic logic any_viol(proto_viol_t v);
        return v.wr_bad | v.st_bad | v.br_bad | v.hdr_bad;
    endfunction
endpackage

// File: rtl/bcd_mask_track.sv
module bcd_mask_track #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic [W-1:0]  load_mask,
    input  logic          ev_valid,
    input  logic [IW-1:0] ev_idx,
    output logic          empty,
    output logic          bad
);
    logic [W-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend <= '0;
        end else if (load) begin
            pend <= load_mask;
        end else if (ev_valid && pend[ev_idx]) begin
            pend[ev_idx] <= 1'b0;
        end
    end

    assign empty = (pend == '0);
    assign bad   = ev_valid && !pend[ev_idx];
endmodule

// File: rtl/bcd_branch_track.sv
module bcd_branch_track (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic armed,
    input  logic br_valid,
    output logic seen,
    output logic bad
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            seen <= 1'b0;
        end else if (br_valid && armed && !seen) begin
            seen <= 1'b1;
        end
    end

    assign bad = br_valid && (!armed || seen);
endmodule

// File: rtl/blk_commit_tracker.sv
module blk_commit_tracker
    import blkdone_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       hdr_valid,
    input  logic [REG_OUTS-1:0]        hdr_wr_mask,
    input  logic [NUM_STORE_IDS-1:0]   hdr_st_mask,
    input  logic                       wr_valid,
    input  logic [BANK_W-1:0]          wr_bank,
    input  logic [SLOT_W-1:0]          wr_slot,
    input  logic                       st_valid,
    input  logic [STID_W-1:0]          st_id,
    input  logic                       br_valid,
    output logic                       busy,
    output logic                       commit_ready,
    output logic                       err
);
    trk_state_e  state;
    proto_viol_t viol;
    reg_tag_t    wr_tag;
    logic        load, clr;
    logic        wr_empty, st_empty, br_seen;

    assign busy   = (state == TRK_BUSY);
    assign load   = hdr_valid && !busy && !flush;
    assign wr_tag = '{bank: wr_bank, slot: wr_slot};
    assign clr    = flush || commit_ready;
    assign viol.hdr_bad = hdr_valid && busy;

    bcd_mask_track #(.W(REG_OUTS), .IW(REG_IW)) u_wr_track (
        .clk(clk), .rst(rst), .clr(clr), .load(load), .load_mask(hdr_wr_mask),
        .ev_valid(wr_valid), .ev_idx(wr_tag), .empty(wr_empty), .bad(viol.wr_bad)
    );

    bcd_mask_track #(.W(NUM_STORE_IDS), .IW(STID_W)) u_st_track (
        .clk(clk), .rst(rst), .clr(clr), .load(load), .load_mask(hdr_st_mask),
        .ev_valid(st_valid), .ev_idx(st_id), .empty(st_empty), .bad(viol.st_bad)
    );

    bcd_branch_track u_br_track (
        .clk(clk), .rst(rst), .clr(clr), .armed(busy),
        .br_valid(br_valid), .seen(br_seen), .bad(viol.br_bad)
    );

    assign commit_ready = busy && wr_empty && st_empty && br_seen && !err;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state <= TRK_IDLE;
            err   <= 1'b0;
        end else begin
            if (load)              state <= TRK_BUSY;
            else if (commit_ready) state <= TRK_IDLE;
            if (any_viol(viol))    err   <= 1'b1;
        end
    end
endmodule

// File: rtl/blk_commit_tracker_chk.sv
module blk_commit_tracker_chk (
    input logic clk,
    input logic rst,
    input logic flush,
    input logic hdr_valid,
    input logic busy,
    input logic commit_ready,
    input logic err
);
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        commit_ready |=> !commit_ready);

    a_r5_idle_after_commit: assert property (@(posedge clk) disable iff (rst)
        commit_ready |=> !busy);

    a_r6_no_commit_on_err: assert property (@(posedge clk) disable iff (rst)
        err |-> !commit_ready);

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err && !flush) |=> err);

    a_r7_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!busy && !err && !commit_ready));

    a_r1_header_starts: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && !busy && !flush) |=> busy);

    a_r8_header_while_busy: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && busy && !flush) |=> err);
endmodule

bind blk_commit_tracker blk_commit_tracker_chk u_chk (
    .clk(clk), .rst(rst), .flush(flush), .hdr_valid(hdr_valid),
    .busy(busy), .commit_ready(commit_ready), .err(err)
);

// File: tb/blk_commit_tracker_bench.sv
module blk_commit_tracker_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, flush, hdr_valid, wr_valid, st_valid, br_valid;
    logic [31:0] hdr_wr_mask, hdr_st_mask;
    logic [1:0]  wr_bank;
    logic [2:0]  wr_slot;
    logic [4:0]  st_id;
    logic        busy, commit_ready, err;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_commit_tracker u_blk_commit_tracker (
        .clk(clk), .rst(rst), .flush(flush), .hdr_valid(hdr_valid),
        .hdr_wr_mask(hdr_wr_mask), .hdr_st_mask(hdr_st_mask),
        .wr_valid(wr_valid), .wr_bank(wr_bank), .wr_slot(wr_slot),
        .st_valid(st_valid), .st_id(st_id), .br_valid(br_valid),
        .busy(busy), .commit_ready(commit_ready), .err(err)
    );

    task automatic idle_inputs();
        flush = 0; hdr_valid = 0; wr_valid = 0; st_valid = 0; br_valid = 0;
    endtask

    // inputs set before the edge are sampled at it; outputs read 1ns later
    task automatic tick();
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    task automatic chk(string req, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic header(logic [31:0] wm, logic [31:0] sm);
        hdr_valid = 1; hdr_wr_mask = wm; hdr_st_mask = sm;
        tick();
    endtask

    task automatic do_flush();
        flush = 1;
        tick();
        chk("R7 busy", busy, 0);
        chk("R7 err", err, 0);
        chk("R7 commit", commit_ready, 0);
    endtask

    initial begin
        rst = 1; idle_inputs();
        hdr_wr_mask = 0; hdr_st_mask = 0; wr_bank = 0; wr_slot = 0; st_id = 0;
        tick(); tick();
        rst = 0;
        tick();
        chk("reset busy", busy, 0);
        chk("reset err", err, 0);
        chk("reset commit", commit_ready, 0);

        // R2: sweep every bank/slot position
        for (int i = 0; i < 32; i++) begin
            header(32'(1) << i, 32'h0);
            chk("R1 busy after header", busy, 1);
            wr_valid = 1; wr_bank = 2'(i / 8); wr_slot = 3'(i % 8);
            tick();
            chk("R4 no commit before branch", commit_ready, 0);
            br_valid = 1;
            tick();
            chk("R2 commit after write", commit_ready, 1);
            chk("R2 no err", err, 0);
            tick();
            chk("R5 pulse ends", commit_ready, 0);
            chk("R5 idle", busy, 0);
        end

        // R3: sweep every store identifier, branch first
        for (int i = 0; i < 32; i++) begin
            header(32'h0, 32'(1) << i);
            br_valid = 1;
            tick();
            chk("R3 waits for store", commit_ready, 0);
            st_valid = 1; st_id = 5'(i);
            tick();
            chk("R3 commit after store", commit_ready, 1);
            tick();
            chk("R5 idle after store block", busy, 0);
        end

        // Full block, reverse order, branch first: commit only on last
        header(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        br_valid = 1;
        tick();
        for (int i = 31; i >= 0; i--) begin
            wr_valid = 1; wr_bank = 2'(i / 8); wr_slot = 3'(i % 8);
            st_valid = 1; st_id = 5'(31 - i);
            tick();
            chk("R2 R3 commit only at end", commit_ready, (i == 0));
        end
        tick();
        chk("R5 full block idle", busy, 0);
        chk("R5 full block pulse ends", commit_ready, 0);

        // Empty header still needs exactly one branch
        header(32'h0, 32'h0);
        chk("R4 empty block waits", commit_ready, 0);
        br_valid = 1;
        tick();
        chk("R4 empty block commits", commit_ready, 1);
        tick();

        // R6: wrong bank (expect bank1 slot1 = bit 9, send bank0 slot1)
        header(32'(1) << 9, 32'h0);
        wr_valid = 1; wr_bank = 2'd0; wr_slot = 3'd1;
        tick();
        chk("R6 wrong bank err", err, 1);
        wr_valid = 1; wr_bank = 2'd1; wr_slot = 3'd1;
        br_valid = 1;
        tick();
        chk("R6 no commit under err", commit_ready, 0);
        tick();
        chk("R6 err sticky", err, 1);
        chk("R6 still no commit", commit_ready, 0);
        do_flush();

        // R6: duplicate store
        header(32'h0, 32'h3);
        st_valid = 1; st_id = 5'd0;
        tick();
        st_valid = 1; st_id = 5'd0;
        tick();
        chk("R6 duplicate store err", err, 1);
        do_flush();

        // R4: second branch
        header(32'h1, 32'h0);
        br_valid = 1;
        tick();
        chk("R4 first branch ok", err, 0);
        br_valid = 1;
        tick();
        chk("R4 second branch err", err, 1);
        do_flush();

        // R8: header while busy
        header(32'h1, 32'h0);
        header(32'h0, 32'h0);
        chk("R8 header while busy err", err, 1);
        do_flush();

        // R9: events while idle
        wr_valid = 1; wr_bank = 0; wr_slot = 0;
        tick();
        chk("R9 idle write err", err, 1);
        do_flush();
        br_valid = 1;
        tick();
        chk("R9 idle branch err", err, 1);
        do_flush();

        // R7: flush mid-block, then a clean block works
        header(32'h1, 32'h1);
        br_valid = 1;
        tick();
        do_flush();
        wr_valid = 1; wr_bank = 0; wr_slot = 0;
        tick();
        chk("R7 no leftover state", err, 1);
        do_flush();
        header(32'h1, 32'h0);
        wr_valid = 1; wr_bank = 0; wr_slot = 0; br_valid = 1;
        tick();
        chk("R7 clean block after flush", commit_ready, 1);
        chk("R7 clean block no err", err, 0);
        tick();

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule